// File: doc/BRIEF.md
# Load/Store Sequencer with Indirect Addressing

This block runs the memory data-movement instructions of a 16-bit processor as a multicycle finite-state machine. It reaches a single-ported word memory only through an internal address register and data register. An accepted instruction word goes through the following steps in order. An effective address is formed, either from the incremented PC plus a signed 9-bit field or from a base register plus a signed 6-bit field. For the indirect forms, a pointer word is read first. Then one read or one write is performed at the final address. For loads, the destination register is written back together with fresh condition codes.

The effective-address instruction only computes the PC-relative address and writes that address itself into the destination register. It makes no memory access. Every memory access holds its address, data and strobe until memory answers with a ready pulse. A one-cycle `done` marks the end of each sequence. Instruction fetch, branches and the register file itself live outside the block. The block points the register file at the base and source registers, and the register file returns their values in the cycle `start` is raised.

Top module: `ldst_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_rd`, `mem_wr`, `wb_en` and `cc_load` are all 0.
- R2: For opcodes (bits [15:12]) 0010 load, 0011 store, 1010 indirect load, 1011 indirect store and 1110 address-only, the first address is `pc_inc` plus bits [8:0] sign-extended, taken modulo 2^16.
- R3: For opcodes 0110 base load and 0111 base store, the address is the register named by bits [8:6] (presented on `rf_base_sel`) plus bits [5:0] sign-extended, modulo 2^16.
- R4: A load (0010, 0110, 1010) ends with exactly one cycle of `wb_en`, in the `done` cycle. `wb_reg` equals bits [11:9] and `wb_data` equals the word read by the final access.
- R5: A store (0011, 0111, 1011) makes exactly one write to memory, and `mem_wdata` is the value of the register named by bits [11:9] (presented on `rf_src_sel`). A store never raises `wb_en` or `cc_load`, and `mem_rd` and `mem_wr` are never high together.
- R6: The indirect forms (1010, 1011) first read the word at the PC-relative address. That word is then the address of the second access, which is a read for 1010 and a write for 1011.
- R7: Opcode 1110 raises no memory strobe. It writes the computed address into register bits [11:9].
- R8: With every writeback `cc_load` is 1 and `cc_nzp` = {N,Z,P} of `wb_data`, with exactly one bit set: N when bit 15 is 1, Z when the value is zero, P otherwise.
- R9: Each access keeps its strobe, `mem_addr` and `mem_wdata` unchanged until a cycle with `mem_ready` high, and the sequence advances only in such a cycle.
- R10: `done` is a single-cycle pulse ending each sequence. `busy` is high from the cycle after `start` is accepted through the `done` cycle.
- R11: `start` is ignored while `busy` is high, and it is also ignored for any opcode not listed in R2 and R3. An ignored `start` causes no strobe, no writeback and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction word valid for one cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | PC already advanced past this instruction |
| rf_base_sel | output | 3 | Register-file read select for the base register (instr bits [8:6]) |
| rf_base_data | input | 16 | Base register value |
| rf_src_sel | output | 3 | Register-file read select for store source (instr bits [11:9]) |
| rf_src_data | input | 16 | Store source register value |
| mem_addr | output | 16 | Memory address register |
| mem_wdata | output | 16 | Memory data register (write data) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes this cycle |
| wb_en | output | 1 | Register writeback enable |
| wb_reg | output | 3 | Writeback register index |
| wb_data | output | 16 | Writeback value |
| cc_load | output | 1 | Condition codes update enable |
| cc_nzp | output | 3 | Condition codes {N,Z,P} |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished this cycle |

## Verification
The hold and handshake properties assume that memory raises `mem_ready` only while a strobe is high, and only for one cycle per access. They also assume that the register-file values are valid in the cycle `start` is accepted. The bench's memory model answers after a programmed number of wait cycles, drops `mem_ready` right after each answer, and returns a word computed from the address. The register values come from a fixed bench array indexed by the select outputs, so the stimulus stays inside these assumptions. Every legal opcode is swept across the field extremes and across zero and nonzero wait counts.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int DW     = 16;
    localparam int RSEL_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_READ,
        ST_WRITE,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic legal;
        logic load;
        logic indirect;
        logic addr_only;
        logic base_mode;
    } op_info_t;

    typedef struct packed {
        seq_state_t        st;
        logic [DW-1:0]     mar;
        logic [DW-1:0]     mdr;
        logic [RSEL_W-1:0] dst;
        logic              load;
        logic              addr_only;
    } seq_regs_t;

    function automatic op_info_t decode_op(input logic [3:0] op);
        op_info_t r;
        r = '0;
        case (op)
            4'b0010: begin r.legal = 1'b1; r.load = 1'b1; end
            4'b0011: begin r.legal = 1'b1; end
            4'b0110: begin r.legal = 1'b1; r.load = 1'b1; r.base_mode = 1'b1; end
            4'b0111: begin r.legal = 1'b1; r.base_mode = 1'b1; end
            4'b1010: begin r.legal = 1'b1; r.load = 1'b1; r.indirect = 1'b1; end
            4'b1011: begin r.legal = 1'b1; r.indirect = 1'b1; end
            4'b1110: begin r.legal = 1'b1; r.addr_only = 1'b1; end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
    parameter int DW      = 16,
    parameter int PCOFF_W = 9,
    parameter int BOFF_W  = 6
) (
    input  logic [DW-1:0] instr,
    input  logic [DW-1:0] pc_inc,
    input  logic [DW-1:0] base,
    input  logic          base_mode,
    output logic [DW-1:0] ea
);
    localparam int PC_PAD = DW - PCOFF_W;
    localparam int B_PAD  = DW - BOFF_W;

    logic [DW-1:0] pc_off;
    logic [DW-1:0] b_off;

    always_comb begin
        pc_off = {{PC_PAD{instr[PCOFF_W-1]}}, instr[PCOFF_W-1:0]};
        b_off  = {{B_PAD{instr[BOFF_W-1]}}, instr[BOFF_W-1:0]};
        ea     = base_mode ? (base + b_off) : (pc_inc + pc_off);
    end
endmodule

// File: rtl/ldst_nzp.sv
module ldst_nzp #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] value,
    output logic [2:0]    nzp
);
    always_comb begin
        if (value[DW-1])       nzp = 3'b100;
        else if (value == '0)  nzp = 3'b010;
        else                   nzp = 3'b001;
    end
endmodule

// File: rtl/ldst_sequencer.sv
module ldst_sequencer
    import ldst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     instr,
    input  logic [DW-1:0]     pc_inc,
    output logic [RSEL_W-1:0] rf_base_sel,
    input  logic [DW-1:0]     rf_base_data,
    output logic [RSEL_W-1:0] rf_src_sel,
    input  logic [DW-1:0]     rf_src_data,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    output logic              wb_en,
    output logic [RSEL_W-1:0] wb_reg,
    output logic [DW-1:0]     wb_data,
    output logic              cc_load,
    output logic [2:0]        cc_nzp,
    output logic              busy,
    output logic              done
);
    localparam int OP_W = 4;

    seq_regs_t     q, d;
    op_info_t      info;
    logic [DW-1:0] ea;

    assign info        = decode_op(instr[DW-1 -: OP_W]);
    assign rf_base_sel = instr[8:6];
    assign rf_src_sel  = instr[11:9];

    ldst_addr_gen #(.DW(DW), .PCOFF_W(9), .BOFF_W(6)) u_agen (
        .instr     (instr),
        .pc_inc    (pc_inc),
        .base      (rf_base_data),
        .base_mode (info.base_mode),
        .ea        (ea)
    );

    ldst_nzp #(.DW(DW)) u_nzp (
        .value (wb_data),
        .nzp   (cc_nzp)
    );

    always_comb begin
        d       = q;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        wb_en   = 1'b0;
        done    = 1'b0;
        wb_data = q.addr_only ? q.mar : q.mdr;
        case (q.st)
            ST_IDLE: begin
                if (start && info.legal) begin
                    d.mar       = ea;
                    d.mdr       = rf_src_data;
                    d.dst       = instr[11:9];
                    d.load      = info.load;
                    d.addr_only = info.addr_only;
                    if (info.addr_only)     d.st = ST_FIN;
                    else if (info.indirect) d.st = ST_PTR;
                    else if (info.load)     d.st = ST_READ;
                    else                    d.st = ST_WRITE;
                end
            end
            ST_PTR: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    d.mar = mem_rdata;
                    d.st  = q.load ? ST_READ : ST_WRITE;
                end
            end
            ST_READ: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    d.mdr = mem_rdata;
                    d.st  = ST_FIN;
                end
            end
            ST_WRITE: begin
                mem_wr = 1'b1;
                if (mem_ready) d.st = ST_FIN;
            end
            ST_FIN: begin
                done  = 1'b1;
                wb_en = q.load | q.addr_only;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign mem_addr  = q.mar;
    assign mem_wdata = q.mdr;
    assign wb_reg    = q.dst;
    assign cc_load   = wb_en;
    assign busy      = (q.st != ST_IDLE);

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    wb_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R8
    cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_load |-> ($countones(cc_nzp) == 1));

    // R11
    illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !info.legal) |=> !busy);

    // R11
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/sim_ldst_sequencer.sv
`timescale 1ns/1ps
module sim_ldst_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_inc = '0;
    logic [2:0]  rf_base_sel, rf_src_sel;
    logic [15:0] rf_base_data, rf_src_data;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        wb_en, cc_load, busy, done;
    logic [2:0]  wb_reg, cc_nzp;
    logic [15:0] wb_data;

    always #2 clk = ~clk;

    logic [15:0] regs [8];
    assign rf_base_data = regs[rf_base_sel];
    assign rf_src_data  = regs[rf_src_sel];

    ldst_sequencer u0 (.*);

    int checks = 0;
    int errors = 0;

    int          waits = 0;
    int          cnt = 0;
    int          acc_n = 0;
    logic        acc_wr [4];
    logic [15:0] acc_a  [4];
    logic [15:0] acc_d  [4];
    int          strb_n = 0;
    int          wb_n = 0;
    logic [2:0]  wb_r;
    logic [15:0] wb_v;
    logic [2:0]  wb_cc;
    int          ccl_n = 0;
    int          done_n = 0;

    function automatic logic [15:0] fmem(input logic [15:0] a);
        if (a == 16'h0042) return 16'h0000;
        return (a * 16'h06B5) ^ 16'hA5C3;
    endfunction

    function automatic logic [2:0] nzp_of(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (instr=%h pc=%h)", req, act, exp, instr, pc_inc);
        end
    endtask

    // memory responder and output monitor
    always @(negedge clk) begin
        if (mem_rd || mem_wr) strb_n++;
        if (wb_en) begin
            wb_n++; wb_r = wb_reg; wb_v = wb_data; wb_cc = cc_nzp;
        end
        if (cc_load) ccl_n++;
        if (done) done_n++;
        if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_rd || mem_wr) begin
            if (cnt == waits) begin
                mem_ready = 1'b1;
                mem_rdata = fmem(mem_addr);
                if (acc_n < 4) begin
                    acc_wr[acc_n] = mem_wr;
                    acc_a[acc_n]  = mem_addr;
                    acc_d[acc_n]  = mem_wr ? mem_wdata : fmem(mem_addr);
                end
                acc_n++;
            end else cnt++;
        end else cnt = 0;
    end

    task automatic clear_logs();
        acc_n = 0; strb_n = 0; wb_n = 0; ccl_n = 0; done_n = 0;
    endtask

    // intrude: pulse a second start while busy
    task automatic run(input logic [15:0] ins, input logic [15:0] pc, input int w, input bit intrude);
        logic [3:0]  op;
        logic [15:0] ea, a2, v;
        bit          is_base, is_ind, is_load, is_lea;
        int          n_exp;
        op = ins[15:12];
        is_base = (op == 4'b0110) || (op == 4'b0111);
        is_ind  = (op == 4'b1010) || (op == 4'b1011);
        is_lea  = (op == 4'b1110);
        is_load = (op == 4'b0010) || (op == 4'b0110) || (op == 4'b1010);
        if (is_base) ea = regs[ins[8:6]] + {{10{ins[5]}}, ins[5:0]};
        else         ea = pc + {{7{ins[8]}}, ins[8:0]};

        @(negedge clk);
        waits = w;
        clear_logs();
        instr = ins; pc_inc = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", {15'b0, busy}, 16'h1);
        if (intrude) begin
            instr = 16'h3E05; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 60; i++) begin
            @(posedge clk);
            if (done_n > 0) break;
        end
        @(negedge clk);
        @(negedge clk);

        chk(done_n == 1, "R10 one done pulse", 16'(done_n), 16'd1);
        chk(busy === 1'b0, "R10 idle after done", {15'b0, busy}, 16'h0);

        a2 = is_ind ? fmem(ea) : ea;
        n_exp = is_lea ? 0 : (is_ind ? 2 : 1);
        chk(acc_n == n_exp, "R6 R7 access count", 16'(acc_n), 16'(n_exp));
        if (n_exp > 0)
            chk(strb_n == (w + 1) + (n_exp - 1) * (w + 2), "R9 strobe held until ready",
                16'(strb_n), 16'((w + 1) + (n_exp - 1) * (w + 2)));
        if (is_ind && acc_n >= 1) begin
            chk(acc_wr[0] == 1'b0, "R6 pointer is a read", {15'b0, acc_wr[0]}, 16'h0);
            chk(acc_a[0] == ea, "R2 R6 pointer address", acc_a[0], ea);
        end
        if (!is_lea && acc_n == n_exp) begin
            chk(acc_wr[n_exp-1] == !is_load, "R4 R5 access direction", {15'b0, acc_wr[n_exp-1]}, {15'b0, !is_load});
            chk(acc_a[n_exp-1] == a2, is_base ? "R3 base address" : "R2 R6 final address", acc_a[n_exp-1], a2);
            if (!is_load)
                chk(acc_d[n_exp-1] == regs[ins[11:9]], "R5 store data", acc_d[n_exp-1], regs[ins[11:9]]);
        end
        if (is_load || is_lea) begin
            v = is_lea ? ea : fmem(a2);
            chk(wb_n == 1, "R4 R7 one writeback", 16'(wb_n), 16'd1);
            chk(wb_r == ins[11:9], "R4 writeback register", {13'b0, wb_r}, {13'b0, ins[11:9]});
            chk(wb_v == v, is_lea ? "R7 address writeback" : "R4 load data", wb_v, v);
            chk(wb_cc == nzp_of(v), "R8 condition codes", {13'b0, wb_cc}, {13'b0, nzp_of(v)});
            chk(ccl_n == 1, "R8 cc_load once", 16'(ccl_n), 16'd1);
        end else begin
            chk(wb_n == 0, "R5 no writeback on store", 16'(wb_n), 16'd0);
            chk(ccl_n == 0, "R5 no cc on store", 16'(ccl_n), 16'd0);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] ops [7];
        logic [8:0] flds [6];
        logic [2:0] drs [3];
        int k;
        ops  = '{4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1010, 4'b1011, 4'b1110};
        flds = '{9'h000, 9'h0FF, 9'h100, 9'h1FF, 9'h05F, 9'h1E0};
        drs  = '{3'd0, 3'd3, 3'd7};
        regs = '{16'h0000, 16'h3100, 16'h8000, 16'h7FFF, 16'h0004, 16'h1234, 16'hC000, 16'hFFFE};

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {14'b0, busy, done}, 16'h0);
        chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R1 reset strobes", {14'b0, mem_rd, mem_wr}, 16'h0);
        chk(wb_en === 1'b0 && cc_load === 1'b0, "R1 reset writeback", {14'b0, wb_en, cc_load}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10
        k = 0;
        for (int o = 0; o < 7; o++)
            for (int f = 0; f < 6; f++)
                for (int r = 0; r < 3; r++)
                    for (int w = 0; w < 3; w += 2) begin
                        run({ops[o], drs[r], flds[f]}, (k % 3 == 0) ? 16'hFFF0 : 16'h3000 + 16'(k), w, 1'b0);
                        k++;
                    end

        // R8 zero results: address-only of 0 and load of a zero word
        run(16'hE200, 16'h0000, 0, 1'b0);
        run(16'h2400, 16'h0042, 1, 1'b0);

        // R11 start during busy is ignored
        run(16'h2A10, 16'h3000, 3, 1'b1);
        run(16'hBC08, 16'h4000, 2, 1'b1);

        // R11 illegal opcodes are ignored
        for (int op = 0; op < 16; op++) begin
            if (op == 2 || op == 3 || op == 6 || op == 7 || op == 10 || op == 11 || op == 14) continue;
            @(negedge clk);
            clear_logs();
            instr = {4'(op), 12'h5A5}; pc_inc = 16'h1000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            chk(strb_n == 0 && done_n == 0 && wb_n == 0 && busy === 1'b0,
                "R11 illegal opcode ignored", 16'(strb_n + done_n + wb_n), 16'h0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule